// File: doc/BRIEF.md
# Serial Four-Bit Constant-Weight Word Checker

This block watches a serial stream of 4-bit codewords and flags the first malformed one. A word is well formed only when exactly one or two of its four bits are set. This weight rule is enough to accept the ten digit codes and reject the other six patterns. Bits enter most significant first, one per clock while the strobe `bit_vld` is high. Clocks with the strobe low leave the machine untouched.

The checker is a Moore machine with the fewest states the rule allows. Each state records two things: the bit position inside the word, and the number of ones seen so far. There are ten states:

- `ST_START`: word boundary.
- `ST_1B0`, `ST_1B1`: one bit seen, with zero or one ones.
- `ST_2B0`, `ST_2B1`, `ST_2B2`: two bits seen, with zero, one or two ones.
- `ST_3B0`, `ST_3B1`, `ST_3B2`: three bits seen, with zero, one or two ones.
- `ST_ERR`: terminal error state.

Each accepted bit moves the machine one position forward and adds one to the ones count when the bit is set. A third one sends the machine from `ST_2B2` to `ST_ERR` at once. At the fourth bit:

- `ST_3B0` goes to `ST_START` on a 1 and to `ST_ERR` on a 0.
- `ST_3B1` always goes to `ST_START`.
- `ST_3B2` goes to `ST_START` on a 0 and to `ST_ERR` on a 1.

`ST_ERR` only leaves on reset. The error flag is decoded from the state register, so it is high from the edge that takes the machine into `ST_ERR` onward.

Top module: `cw4_checker`

## Requirements
- R1: A synchronous active-high `rst` puts the machine at a word boundary with `err_flag` low after the clock edge.
- R2: A clock with `bit_vld` low changes neither the state nor `err_flag`. Idle gaps inside a word do not alter its verdict.
- R3: Each of the ten words with exactly one or two set bits leaves `err_flag` at 0 during and after the word.
- R4: The word 0000 raises `err_flag` at the edge that accepts its fourth bit.
- R5: A word with three or four set bits raises `err_flag` at the edge that accepts its third set bit. Bits count in arrival order, most significant first.
- R6: Once raised, `err_flag` stays at 1 through later valid words and idle clocks until `rst`.
- R7: After the fourth bit of a valid word, the next accepted bit starts a new word with the ones count cleared.
- R8: A reset in the middle of a word discards the partial word. Counting restarts at the next accepted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial codeword bit, most significant first |
| bit_vld | input | 1 | Strobe: `bit_in` is accepted on this edge |
| err_flag | output | 1 | Sticky error indication |

## Verification
The assertions assume that `rst` is high on the first clock edge and that `bit_in` and `bit_vld` are known at every edge after that. Under those assumptions, the claims that the flag only rises on an accepted bit and that idle clocks hold the state are well defined. The stimulus holds reset from time zero. It changes inputs only one time unit after a rising edge, so every edge samples settled, defined values. Idle gaps are inserted mid-word to test the hold claim with real data around it.

// File: rtl/cw4_pkg.sv
package cw4_pkg;

    localparam int WORD_BITS  = 4;
    localparam int STATE_BITS = 4;

    // Position in word (1..3 bits seen) and ones seen so far.
    typedef enum logic [STATE_BITS-1:0] {
        ST_START = 4'd0,
        ST_1B0   = 4'd1,
        ST_1B1   = 4'd2,
        ST_2B0   = 4'd3,
        ST_2B1   = 4'd4,
        ST_2B2   = 4'd5,
        ST_3B0   = 4'd6,
        ST_3B1   = 4'd7,
        ST_3B2   = 4'd8,
        ST_ERR   = 4'd9
    } cw_state_t;

endpackage

// File: rtl/cw4_step.sv
module cw4_step
    import cw4_pkg::*;
(
    input  cw_state_t cur,
    input  logic      bit_in,
    output cw_state_t nxt
);

    always_comb begin
        nxt = ST_ERR;
        unique case (cur)
            ST_START: nxt = bit_in ? ST_1B1   : ST_1B0;
            ST_1B0:   nxt = bit_in ? ST_2B1   : ST_2B0;
            ST_1B1:   nxt = bit_in ? ST_2B2   : ST_2B1;
            ST_2B0:   nxt = bit_in ? ST_3B1   : ST_3B0;
            ST_2B1:   nxt = bit_in ? ST_3B2   : ST_3B1;
            ST_2B2:   nxt = bit_in ? ST_ERR   : ST_3B2;  // third one: fail early
            ST_3B0:   nxt = bit_in ? ST_START : ST_ERR;  // weight 0 or 1
            ST_3B1:   nxt = ST_START;                    // weight 1 or 2
            ST_3B2:   nxt = bit_in ? ST_ERR   : ST_START;// weight 3 or 2
            ST_ERR:   nxt = ST_ERR;
            default:  nxt = ST_ERR;                      // unused encodings
        endcase
    end

endmodule

// File: rtl/cw4_state_reg.sv
module cw4_state_reg
    import cw4_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  cw_state_t nxt,
    output cw_state_t state
);

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_START;
        else if (adv)
            state <= nxt;
    end

    // R1: reset lands on a word boundary
    assert_reset_boundary_R1: assert property (@(posedge clk)
        rst |=> (state == ST_START));

    // R2: idle clocks hold the state
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));

    // R6: error state is terminal
    assert_err_terminal_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERR) |=> (state == ST_ERR));

endmodule

// File: rtl/cw4_checker.sv
module cw4_checker
    import cw4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    output logic err_flag
);

    cw_state_t state;
    cw_state_t nxt;

    cw4_step i_step (
        .cur    (state),
        .bit_in (bit_in),
        .nxt    (nxt)
    );

    cw4_state_reg i_reg (
        .clk   (clk),
        .rst   (rst),
        .adv   (bit_vld),
        .nxt   (nxt),
        .state (state)
    );

    // Moore output decode
    always_comb begin
        err_flag = (state == ST_ERR);
    end

    // R5: flag only rises on an accepted bit
    assert_rise_on_bit_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(bit_vld));

    // R6: flag never drops without reset
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R7: fourth bit always ends at a boundary or in error
    assert_word_end_R7: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && (state inside {ST_3B0, ST_3B1, ST_3B2}))
        |=> (state inside {ST_START, ST_ERR}));

endmodule

// File: tb/test_cw4_checker.sv
module test_cw4_checker;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic err_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cw4_checker i_cw4_checker (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (bit_in),
        .bit_vld  (bit_vld),
        .err_flag (err_flag)
    );

    task automatic check(input logic exp, input string req);
        n_vec++;
        if (err_flag !== exp) begin
            n_bad++;
            $display("FAIL %s: err_flag=%b expected=%b at %0t", req, err_flag, exp, $time);
        end
    endtask

    // Inputs change 1 unit after the edge; the check reads after that edge.
    task automatic send_bit(input logic b);
        bit_in  = b;
        bit_vld = 1'b1;
        @(posedge clk); #1;
        bit_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        bit_vld = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bit_vld = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    // Bit index (1..4) at which the word fails, 0 if valid.
    function automatic int fail_at(input logic [3:0] w);
        int ones = 0;
        for (int i = 3; i >= 0; i--) begin
            ones += w[i];
            if (ones == 3) return 4 - i;
        end
        return (ones == 0) ? 4 : 0;
    endfunction

    task automatic t_reset();
        do_reset();
        check(1'b0, "R1 reset state");
    endtask

    task automatic t_valid_words();
        do_reset();
        for (int p = 0; p < 16; p++) begin
            if (fail_at(p[3:0]) == 0) begin
                for (int i = 3; i >= 0; i--) begin
                    send_bit(p[i]);
                    check(1'b0, "R3 valid word");
                end
            end
        end
    endtask

    task automatic t_invalid_words();
        for (int p = 0; p < 16; p++) begin
            int f = fail_at(p[3:0]);
            if (f != 0) begin
                do_reset();
                for (int i = 3; i >= 0; i--) begin
                    send_bit(p[i]);
                    if (p == 0) check((4 - i) >= f, "R4 all-zero word");
                    else        check((4 - i) >= f, "R5 heavy word");
                end
            end
        end
    endtask

    task automatic t_idle_gaps();
        do_reset();
        // 1 0 _ _ 0 _ 1 -> weight 2, valid
        send_bit(1'b1); idle(2); send_bit(1'b0); idle(3);
        send_bit(1'b0); idle(1); send_bit(1'b1);
        check(1'b0, "R2 gaps in valid word");
        // 1 1 _ _ 1 -> error at third bit; idle keeps flag
        send_bit(1'b1); send_bit(1'b1); idle(4);
        check(1'b0, "R2 idle does not count");
        send_bit(1'b1);
        check(1'b1, "R2 gaps then third one");
    endtask

    task automatic t_boundaries();
        do_reset();
        // 0011 then 1100: each weight 2, must not combine
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        check(1'b0, "R7 ones cleared at boundary");
        // 0001 then 0001
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        check(1'b0, "R7 position cleared at boundary");
    endtask

    task automatic t_sticky();
        do_reset();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        check(1'b1, "R6 error raised");
        send_bit(1'b0);
        for (int k = 0; k < 3; k++) begin
            send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        end
        idle(5);
        check(1'b1, "R6 sticky after valid words");
        do_reset();
        check(1'b0, "R6 reset clears error");
    endtask

    task automatic t_reset_midword();
        do_reset();
        send_bit(1'b1); send_bit(1'b1);
        do_reset();
        // 1100 valid only if the two earlier ones were discarded
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        check(1'b0, "R8 partial word dropped");
        do_reset();
        send_bit(1'b0); send_bit(1'b1);
        do_reset();
        // 0000 must fail at bit 4, proving realignment
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        check(1'b0, "R8 realigned before bit 4");
        send_bit(1'b0);
        check(1'b1, "R8 realigned at bit 4");
    endtask

    initial begin
        #1;
        t_reset();
        t_valid_words();
        t_invalid_words();
        t_idle_gaps();
        t_boundaries();
        t_sticky();
        t_reset_midword();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule